// File: doc/BRIEF.md
# Row-major pixel to vertical page packer

This block turns a frame held as one pixel word per location, stored row after row, into the byte stream that a monochrome OLED controller takes in vertical addressing mode. Each output byte covers one column and eight stacked rows, called a page. A pixel counts as lit when its word is nonzero. The block walks the frame in column-major order. For each byte it issues eight reads to a synchronous pixel memory with one cycle of latency, gathers the eight lit/unlit bits and presents the finished byte on a valid/ready stream. The data/command flag is held high.

A one-cycle start pulse launches a frame. The frame ends when its last byte has been accepted, and a one-cycle done pulse follows. Geometry is set by the `COLS` and `ROWS` parameters, where `ROWS` is a multiple of 8. The defaults are 128 by 64 with 16-bit pixel words.

Back-pressure works as follows. A byte on the output stays put until it is taken, and `out_valid_o` and `out_data_o` do not change while `out_ready_i` is low. A transfer happens on a rising edge where both valid and ready are high. In any cycle where a byte is held and not taken, no memory read is issued, so the reads for the following byte stall with the output.

Top module: `page_packer`

## Requirements
- R1: Bytes leave in column-major order. For column x from 0 to COLS-1 and, within each column, page p from 0 to ROWS/8-1, byte number x*(ROWS/8)+p is the byte for (x, p).
- R2: In the byte for (x, p), bit i (bit 0 is the least significant) is 1 exactly when the pixel word at row p*8+i and column x is nonzero. A word that has only its top bit set counts as nonzero.
- R3: The pixel at row r and column x is read from address r*COLS+x, with `mem_rd_o` high in the read cycle. The memory returns the word in the following cycle. The eight reads for byte (x, p) come in row order p*8 to p*8+7.
- R4: A frame delivers exactly COLS*ROWS/8 bytes, and `out_dc_o` is high on every one of them.
- R5: While `out_ready_i` stays high, reads go on in every cycle from the cycle after the start edge until all COLS*ROWS reads are done. The done pulse comes 8*(COLS*ROWS/8)+3 cycles after the start edge.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `mem_rd_o` is low. In the next cycle `out_valid_o` is still high and `out_data_o` is unchanged.
- R7: `frame_done_o` is high for exactly one cycle. That cycle is the one right after the edge where the last byte of the frame was accepted.
- R8: A start pulse from the cycle after the accepted start up to the cycle before the done pulse is ignored. It neither restarts the frame nor queues a second frame.
- R9: In reset and until the first start, `out_valid_o`, `mem_rd_o` and `frame_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a frame |
| mem_rd_o | output | 1 | Pixel memory read enable |
| mem_addr_o | output | $clog2(COLS*ROWS) | Pixel memory address, row*COLS+column |
| mem_data_i | input | PIX_W | Pixel word, valid the cycle after the read |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted when high with valid |
| out_data_o | output | 8 | Packed page byte, bit 0 is the top row |
| out_dc_o | output | 1 | Data/command flag, high for data |
| frame_done_o | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
The bench runs several frames, each with its own pixel pattern. Dense random words catch a wrong bit order or a swapped page or column. A pattern where each lit pixel has only its top bit set tells a true any-bit-nonzero test apart from a test on bit 0 alone. All-zero and all-lit frames catch stuck bits. A frame with ready held high checks every read address and the exact cycle count to the done pulse. Frames with ready randomly low check that the held byte stays stable and that reads stop during stalls. One of them also fires a stray start mid-frame to show it neither restarts nor queues a frame.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Tag carried alongside each pixel read until its word returns.
  typedef struct packed {
    logic       last;     // final read of the frame
    logic [2:0] bit_idx;  // row within the page
  } rd_tag_t;
endpackage

// File: rtl/pp_walker.sv
module pp_walker #(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  parameter int AW   = $clog2(COLS*ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              issue_i,
  output logic [AW-1:0]     addr_o,
  output pp_pkg::rd_tag_t   tag_o,
  output logic              spent_o
);
  localparam int PAGES = ROWS / 8;
  localparam int XW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic [XW-1:0] x_q;
  logic [PW-1:0] p_q;
  logic [2:0]    i_q;
  logic          spent_q;
  logic          i_wrap, p_wrap, x_wrap;

  assign i_wrap = (i_q == 3'd7);
  assign p_wrap = (p_q == PW'(PAGES-1));
  assign x_wrap = (x_q == XW'(COLS-1));

  // Bit counter walks rows inside a page.
  always_ff @(posedge clk) begin
    if (!rst_n || load_i) i_q <= '0;
    else if (issue_i)     i_q <= i_q + 3'd1;
  end

  // Page counter; absent when the frame is a single page tall.
  generate
    if (PAGES > 1) begin : g_pages
      always_ff @(posedge clk) begin
        if (!rst_n || load_i) p_q <= '0;
        else if (issue_i && i_wrap) p_q <= p_wrap ? '0 : p_q + PW'(1);
      end
    end else begin : g_one_page
      assign p_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || load_i) x_q <= '0;
    else if (issue_i && i_wrap && p_wrap && !x_wrap) x_q <= x_q + XW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       spent_q <= 1'b1;
    else if (load_i)  spent_q <= 1'b0;
    else if (issue_i && tag_o.last) spent_q <= 1'b1;
  end

  logic [AW-1:0] row;
  assign row           = AW'({p_q, i_q});
  assign addr_o        = row * AW'(COLS) + AW'(x_q);
  assign tag_o.bit_idx = i_q;
  assign tag_o.last    = i_wrap && p_wrap && x_wrap;
  assign spent_o       = spent_q;

  assert_addr_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (int'(addr_o) < COLS*ROWS));
  assert_rows_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !load_i && !tag_o.last) |=> (tag_o.bit_idx == $past(tag_o.bit_idx) + 3'd1));
endmodule

// File: rtl/pp_gather.sv
module pp_gather #(
  parameter int PIX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire_i,
  input  pp_pkg::rd_tag_t   rd_tag_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_last_o
);
  pp_pkg::rd_tag_t tag_q;
  logic            tag_v_q;
  logic [6:0]      acc_q;
  logic            lit;

  assign lit = |pix_i;

  // Tag follows the read by the memory latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_v_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      tag_v_q <= rd_fire_i;
      tag_q   <= rd_tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (tag_v_q && tag_q.bit_idx != 3'd7) acc_q[tag_q.bit_idx] <= lit;
  end

  // Output holding register: loads on the eighth bit, clears on accept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else if (tag_v_q && tag_q.bit_idx == 3'd7) begin
      out_valid_o <= 1'b1;
      out_data_o  <= {lit, acc_q};
      out_last_o  <= tag_q.last;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_v_q && tag_q.bit_idx == 3'd7) |-> (!out_valid_o || out_ready_i));
endmodule

// File: rtl/page_packer.sv
module page_packer #(
  parameter int COLS  = 128,
  parameter int ROWS  = 64,
  parameter int PIX_W = 16,
  localparam int AW   = $clog2(COLS*ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             mem_rd_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [PIX_W-1:0] mem_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_dc_o,
  output logic             frame_done_o
);
  logic            running_q, done_q;
  logic            take_start, spent, out_free, issue;
  logic            out_last, accept_last;
  pp_pkg::rd_tag_t tag;

  assign take_start  = start_i && !running_q;
  assign out_free    = !out_valid_o || out_ready_i;
  assign issue       = running_q && !spent && out_free;
  assign accept_last = out_valid_o && out_ready_i && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= accept_last;
      if (take_start)       running_q <= 1'b1;
      else if (accept_last) running_q <= 1'b0;
    end
  end

  pp_walker #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take_start),
    .issue_i (issue),
    .addr_o  (mem_addr_o),
    .tag_o   (tag),
    .spent_o (spent)
  );

  pp_gather #(.PIX_W(PIX_W)) u_gather (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire_i   (issue),
    .rd_tag_i    (tag),
    .pix_i       (mem_data_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last)
  );

  assign mem_rd_o     = issue;
  assign out_dc_o     = 1'b1;
  assign frame_done_o = done_q;

  assert_stall_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> !mem_rd_o);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $past(out_valid_o && out_ready_i));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (!mem_rd_o && !out_valid_o));
endmodule

// File: tb/page_packer_test.sv
module page_packer_test;
  localparam int C  = 16;
  localparam int R  = 16;
  localparam int P  = R / 8;
  localparam int NB = C * R / 8;
  localparam int AW = $clog2(C*R);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ready = 1'b0;
  logic          mem_rd, valid, dc, done;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_q;
  logic [7:0]    data;
  logic [15:0]   pix [C*R];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  page_packer #(.COLS(C), .ROWS(R), .PIX_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(data),
    .out_dc_o(dc), .frame_done_o(done)
  );

  always_ff @(posedge clk) if (mem_rd) mem_q <= pix[mem_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    int x = k / P;
    int p = k % P;
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) b[i] = (pix[(p*8+i)*C + x] != 16'h0);
    return b;
  endfunction

  function automatic int exp_addr(input int j);
    int x = j / (8*P);
    int p = (j / 8) % P;
    int i = j % 8;
    return (p*8+i)*C + x;
  endfunction

  // mode: 0 random, 1 top-bit-only sparse, 2 all zero, 3 all lit
  task automatic fill(input int mode);
    for (int a = 0; a < C*R; a++) begin
      case (mode)
        0: pix[a] = 16'($urandom);
        1: pix[a] = ($urandom % 2) ? 16'h8000 : 16'h0000;
        2: pix[a] = 16'h0000;
        default: pix[a] = 16'h0001 << ($urandom % 16);
      endcase
      if (mode == 0 && ($urandom % 3) == 0) pix[a] = 16'h0;
    end
  endtask

  task automatic run_frame(input int ready_pct, input bit stray, input bit timed);
    int nb = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    bit got_done = 0;
    @(negedge clk);
    start = 1'b1;
    ready = 1'b1;
    @(negedge clk);
    for (int c = 1; c < 4000; c++) begin
      start = (stray && c == 20);
      ready = timed ? 1'b1 : (($urandom % 100) < ready_pct);
      #1;
      if (timed && c <= 8*NB) begin
        check(mem_rd == 1'b1, "R5 read every cycle", int'(mem_rd), 1);
        check(int'(mem_addr) == exp_addr(c-1), "R3 read address", int'(mem_addr), exp_addr(c-1));
      end
      if (stalled) begin
        check(valid == 1'b1, "R6 valid held", int'(valid), 1);
        check(data == held, "R6 data held", int'(data), int'(held));
      end
      stalled = 0;
      if (valid && !ready) begin
        check(mem_rd == 1'b0, "R6 no read in stall", int'(mem_rd), 0);
        stalled = 1;
        held = data;
      end
      if (valid && ready) begin
        check(data == exp_byte(nb), "R1 R2 byte value/order", int'(data), int'(exp_byte(nb)));
        check(dc == 1'b1, "R4 dc flag", int'(dc), 1);
        nb++;
      end
      if (done) begin
        check(nb == NB, "R4 byte count", nb, NB);
        if (timed) check(c == 8*NB+3, "R5 done cycle", c, 8*NB+3);
        got_done = 1;
        break;
      end
      @(negedge clk);
    end
    check(got_done, "R7 done seen", int'(got_done), 1);
    start = 1'b0;
    @(negedge clk);
    #1;
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      #1;
      if (mem_rd || valid || done) begin
        check(1'b0, "R8 quiet after frame", int'(mem_rd | valid | done), 0);
        break;
      end
    end
    check(1'b1, "R8 quiet after frame", 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(valid == 1'b0, "R9 valid in reset", int'(valid), 0);
    check(mem_rd == 1'b0, "R9 read in reset", int'(mem_rd), 0);
    check(done == 1'b0, "R9 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!valid && !mem_rd && !done, "R9 idle after reset", int'(valid | mem_rd | done), 0);

    fill(0); run_frame(100, 1'b0, 1'b1);
    fill(1); run_frame(60, 1'b0, 1'b0);
    fill(0); run_frame(35, 1'b1, 1'b0);
    fill(2); run_frame(50, 1'b0, 1'b0);
    fill(3); run_frame(80, 1'b0, 1'b0);
    fill(1); run_frame(100, 1'b0, 1'b1);
    finish_run();
  end
endmodule